// File: doc/BRIEF.md
# Alternating-Pair Bridge PWM Generator

This block produces edge-aligned pulse-width modulation on four channels (A, B, C and D) from a single shared up-counting timebase. Each channel has its own compare value and its own polarity select. One top value sets the length of the period, and all four channels share it.

The channels form two fixed pairs: A with B, and C with D. Each pair has an enable bit that puts it into alternating mode. In that mode the pair's two outputs take turns: one counter period passes the first channel and the next passes the second. The channel that is gated off sits at its inactive level. This makes one pair suitable for driving the two halves of an H-bridge on alternate periods. The block also emits a one-cycle pulse that marks each period boundary.

Every output change caused by a compare or wrap event is registered, so it shows on the clock cycle after the event.

Top module: `bpwm_bridge`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous) and in the first cycle after it, the counter is 0, every channel's raw state is 0 and wrap_o is 0.
- R2: The counter advances by one per clock. In the cycle where it is greater than or equal to top_i, the next value is 0 instead. wrap_o is high for exactly the one cycle that follows that wrap event.
- R3: With inv_i[k]=0 and the channel not gated off, pwm_o[k] goes high in the cycle after the counter equals that channel's compare value. It stays high through the cycle in which the counter equals top_i and is low otherwise. A compare value that is equal to or above top_i therefore gives a constant low.
- R4: With inv_i[k]=1, pwm_o[k] is the complement of the R3 waveform.
- R5: Channel index 0 is A, 1 is B, 2 is C and 3 is D. The compare value of channel k is cmp_i[k*CW +: CW]. alt_en_i[0] controls pair A/B and alt_en_i[1] controls pair C/D.
- R6: While a pair's enable bit is set, the pair has a phase bit that flips at every wrap event. Phase 0 passes only the first channel of the pair (A or C) and phase 1 passes only the second (B or D).
- R7: A channel that is gated off by its pair drives its inactive level on pwm_o: 0 when inv_i is 0, 1 when inv_i is 1.
- R8: While a pair's enable bit is clear, both channels of the pair run in every period and the pair's phase is reset to 0. After the bit is set again, the first channel of the pair is the one passed.
- R9: The two pairs are independent. Enabling or toggling alternation on one pair has no effect on the other pair's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| top_i | input | CW | Last count value of a period |
| cmp_i | input | 4*CW | Compare values, channel k at bits k*CW +: CW |
| alt_en_i | input | 2 | Alternating-mode enable per pair (bit 0 A/B, bit 1 C/D) |
| inv_i | input | 4 | Per-channel inverted-output select |
| pwm_o | output | 4 | PWM pins, bit 0 A to bit 3 D |
| wrap_o | output | 1 | One-cycle period-boundary pulse |

## Verification
The bench runs the channels with compare values of zero, mid-range, equal to the top value and above it. This separates the set-on-match edge from the clear-on-wrap edge and from the never-set case. The same settings are then repeated with mixed polarity selects, so that inversion can be told apart from gating. Alternation is enabled on one pair at a time and then on both. It is then cleared and set again in the middle of a period, which exposes errors in the phase order, in the phase reset, in the inactive level and in leakage between pairs.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  localparam int unsigned NCH   = 4;
  localparam int unsigned NPAIR = NCH / 2;

  // Period ends when the count reaches or passes the top value
  function automatic logic f_wrap(input logic [15:0] cnt, input logic [15:0] top);
    return cnt >= top;
  endfunction

  // Next raw channel state: wrap clears, match sets, otherwise hold
  function automatic logic f_next_q(input logic q, input logic wrap, input logic match);
    if (wrap)       return 1'b0;
    else if (match) return 1'b1;
    else            return q;
  endfunction

  // Pin level: passed channel applies polarity, gated channel sits inactive
  function automatic logic f_pin(input logic q, input logic pass, input logic inv);
    return pass ? (q ^ inv) : inv;
  endfunction
endpackage

// File: rtl/bpwm_timebase.sv
module bpwm_timebase #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] top_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_evt_o,
  output logic          wrap_o
);
  import bpwm_pkg::*;

  logic [CW-1:0] cnt_q;
  logic          wrap_q;

  assign wrap_evt_o = f_wrap(16'(cnt_q), 16'(top_i));
  assign cnt_o      = cnt_q;
  assign wrap_o     = wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= wrap_evt_o ? '0 : cnt_q + 1'b1;
      wrap_q <= wrap_evt_o;
    end
  end

  // R2: the cycle after a wrap event starts at zero
  p_cnt_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt_o |=> (cnt_q == '0));
  // R2: boundary pulse lasts one cycle when the period is longer than one
  p_wrap_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && top_i != '0) |=> !wrap_q);
endmodule

// File: rtl/bpwm_channel.sv
module bpwm_channel #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          wrap_evt_i,
  output logic          q_o
);
  import bpwm_pkg::*;

  logic match;
  logic q;

  assign match = (cnt_i == cmp_i);
  assign q_o   = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= f_next_q(q, wrap_evt_i, match);
  end

  // R3: a match away from the wrap sets the raw state next cycle
  p_set_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !wrap_evt_i) |=> q);
  // R3: every wrap clears the raw state
  p_clear_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt_i |=> !q);
endmodule

// File: rtl/bpwm_alt_gate.sv
module bpwm_alt_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alt_en_i,
  input  logic       wrap_evt_i,
  input  logic [1:0] q_i,
  input  logic [1:0] inv_i,
  output logic [1:0] pin_o,
  output logic       phase_o
);
  import bpwm_pkg::*;

  logic       phase;
  logic [1:0] pass;

  assign pass[0] = !alt_en_i || !phase;
  assign pass[1] = !alt_en_i ||  phase;
  assign phase_o = phase;

  for (genvar j = 0; j < 2; j++) begin : g_pin
    assign pin_o[j] = f_pin(q_i[j], pass[j], inv_i[j]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase <= 1'b0;
    else if (!alt_en_i) phase <= 1'b0;
    else if (wrap_evt_i) phase <= !phase;
  end

  // R6: phase flips at each wrap while alternating
  p_phase_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_en_i && wrap_evt_i) |=> (phase != $past(phase)));
  // R8: disabled pair has phase 0
  p_phase_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_en_i |=> !phase);
  // R7: gated-off channel sits at its inactive level
  p_gated_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_en_i && !phase) |-> (pin_o[1] == inv_i[1]));
endmodule

// File: rtl/bpwm_bridge.sv
module bpwm_bridge #(
  parameter int unsigned CW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CW-1:0]             top_i,
  input  logic [bpwm_pkg::NCH*CW-1:0] cmp_i,
  input  logic [bpwm_pkg::NPAIR-1:0] alt_en_i,
  input  logic [bpwm_pkg::NCH-1:0]   inv_i,
  output logic [bpwm_pkg::NCH-1:0]   pwm_o,
  output logic                      wrap_o
);
  import bpwm_pkg::*;

  logic [CW-1:0]    cnt;
  logic             wrap_evt;
  logic [NCH-1:0]   raw_q;
  logic [NPAIR-1:0] phase;

  bpwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .top_i(top_i),
    .cnt_o(cnt), .wrap_evt_o(wrap_evt), .wrap_o(wrap_o)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    bpwm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt),
      .cmp_i(cmp_i[k*CW +: CW]), .wrap_evt_i(wrap_evt), .q_o(raw_q[k])
    );
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    bpwm_alt_gate u_gate (
      .clk(clk), .rst_n(rst_n), .alt_en_i(alt_en_i[p]),
      .wrap_evt_i(wrap_evt), .q_i(raw_q[2*p +: 2]), .inv_i(inv_i[2*p +: 2]),
      .pin_o(pwm_o[2*p +: 2]), .phase_o(phase[p])
    );
  end

  // R9: phases of the two pairs can only move on a wrap
  p_phase_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> ($past(alt_en_i) != alt_en_i) || ((phase & alt_en_i) == ($past(phase) & alt_en_i)));
endmodule

// File: tb/tb_bpwm_bridge.sv
module tb_bpwm_bridge;
  localparam int CW = 8;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] top_i = 8'd9;
  logic [4*CW-1:0] cmp_i = '0;
  logic [1:0]    alt_en_i = '0;
  logic [3:0]    inv_i = '0;
  logic [3:0]    pwm_o;
  logic          wrap_o;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  logic [4:0] expq[$];
  bit done = 0;

  bpwm_bridge #(.CW(CW)) dut (.*);

  always #5 clk = ~clk;

  // reference state from the requirements
  int mc = 0; bit mq[4]; bit mph[2]; bit mw = 0;

  function automatic logic [4:0] expect_now();
    logic [4:0] e;
    for (int k = 0; k < 4; k++) begin
      bit pass;
      pass = (alt_en_i[k/2] == 1'b0) || (mph[k/2] == bit'(k % 2));
      e[k] = pass ? (mq[k] ^ inv_i[k]) : inv_i[k];
    end
    e[4] = mw;
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mc = 0; mw = 0;
      for (int k = 0; k < 4; k++) mq[k] = 0;
      for (int p = 0; p < 2; p++) mph[p] = 0;
    end else begin
      bit w;
      w = (mc >= int'(top_i));
      for (int k = 0; k < 4; k++)
        if (w) mq[k] = 0;
        else if (mc == int'(cmp_i[k*CW +: CW])) mq[k] = 1;
      for (int p = 0; p < 2; p++)
        mph[p] = alt_en_i[p] ? (w ? !mph[p] : mph[p]) : 0;
      mw = w;
      mc = w ? 0 : mc + 1;
    end
    expq.push_back(expect_now());
  end

  // monitor: compare away from the edge
  always @(posedge clk) begin
    #3;
    if (expq.size() > 0) begin
      logic [4:0] e;
      e = expq.pop_front();
      n_chk++;
      if ({wrap_o, pwm_o} !== e) begin
        n_fail++;
        $display("FAIL %s: wrap/pins actual %b_%b expected %b_%b", tag, wrap_o, pwm_o, e[4], e[3:0]);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmp(input int a, input int b, input int c, input int d);
    cmp_i = {8'(d), 8'(c), 8'(b), 8'(a)};
  endtask

  initial begin
    fork
      begin
        // R1: reset state
        tag = "R1";
        run(3);
        n_chk++;
        if (pwm_o !== 4'b0000 || wrap_o !== 1'b0) begin
          n_fail++;
          $display("FAIL R1: reset actual %b_%b expected 0_0000", wrap_o, pwm_o);
        end
        rst_n = 1'b1;
        // R2 R3: base waveform, compare zero, mid, equal top, above top
        tag = "R2 R3 R5";
        set_cmp(0, 4, 9, 12);
        run(35);
        // R4: inverted polarity on B and D
        tag = "R4 R5";
        inv_i = 4'b1010;
        run(30);
        // R6 R7: alternate pair A/B only, other pair untouched (R9)
        tag = "R6 R7 R9";
        set_cmp(2, 5, 3, 7);
        inv_i = 4'b0010;
        alt_en_i = 2'b01;
        run(45);
        // R6: both pairs alternate, inverted gated channels idle high
        tag = "R6 R7";
        inv_i = 4'b1001;
        alt_en_i = 2'b11;
        run(45);
        // R8: clear mid period, then set again
        tag = "R8";
        run(4);
        alt_en_i = 2'b10;
        run(23);
        alt_en_i = 2'b11;
        run(25);
        // R2: shorter period mid run
        tag = "R2 R3";
        alt_en_i = 2'b00;
        inv_i = 4'b0000;
        top_i = 8'd4;
        set_cmp(1, 0, 3, 4);
        run(25);
        // R1: reset again mid stream
        tag = "R1";
        rst_n = 1'b0;
        run(2);
        rst_n = 1'b1;
        run(10);
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog: actual hung expected done");
        end
      end
    join_any
    #20;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule